// File: doc/BRIEF.md
# Processor-to-Host Transaction Translator

This block is the slave-side front end of a bridge between a 64-bit processor bus and a host interface. The processor bus multiplexes address and data. In the address phase, the low bits carry a 36-bit physical address and the bits above them carry the transaction attributes. The block captures those attributes in the cycle the address strobe is seen. It then issues one host request, or two chained host requests, with discrete attributes: data width 32 or 64, single or burst, a partial byte count for narrow singles, and a burst length code.

Writes are posted. The processor is told "ready" one cycle after the address phase, while the host write is still in flight. The block holds one transaction at a time. A new address phase that arrives while a host request is outstanding is answered with a retry, so the processor master backs off and tries again later. Reads are not posted. Ready, or a bus error, is returned only when the host side completes.

The host side uses a plain request/acknowledge handshake. The request and its attributes stay stable until the acknowledge is seen. An error flag that is valid with the acknowledge reports a failed host transfer.

Top module: `ptoh_xlate`

## Requirements
- R1: When `p_as` is high and no host request is outstanding, the block captures the request. From the next cycle, `h_req` is high, `h_addr` equals `p_ad[35:0]` and `h_wr` equals `p_ad[36]`. The size code is taken from `p_ad[39:37]`; bits 63:40 have no effect.
- R2: Size code 0 (1 byte) and code 1 (2 bytes) give `h_dw64`=0 and `h_burst`=0. They give `h_tsize`=01 for code 0 and `h_tsize`=10 for code 1.
- R3: Size code 2 (4 bytes) gives `h_dw64`=0, `h_burst`=0 and `h_tsize`=00 (full single).
- R4: Size codes 3, 4, 5 and 6 (8, 16, 32 and 64 bytes) give `h_dw64`=1, `h_burst`=1 and `h_tsize`=00. They give `h_blen` = 0, 1, 2 and 3 respectively (8, 16, 32 and 64 bytes). Singles give `h_blen`=0.
- R5: Size code 7 (128 bytes) issues two 64-byte bursts (`h_blen`=3). The first has `h_more`=1 and the captured address. In the cycle after its acknowledge, the second is requested with `h_more`=0 and the address plus 64, modulo 2^36. All other requests have `h_more`=0.
- R6: An accepted write raises `p_rdy` for exactly one cycle, in the cycle right after the address phase, whatever the state of the host side. Completion of a host write never raises `p_rdy` or `p_err`.
- R7: An address phase seen while a host request is outstanding raises `p_rty` for one cycle in the next cycle. It raises neither `p_rdy` nor `p_err`, and leaves the outstanding host request's address and attributes unchanged.
- R8: For a read, `p_rdy` stays low until the final host acknowledge. It is high for exactly the one cycle after that acknowledge when `h_err` was low.
- R9: An acknowledge with `h_err` high ends the transaction, and no second chunk is issued. For a read, `p_err` is high for the one cycle after it, with `p_rdy` low.
- R10: After reset, `h_req`, `h_more`, `p_rdy`, `p_rty` and `p_err` are low.
- R11: `h_req` and all host attributes stay stable until `h_ack`. An `h_ack` with no request outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p_as | input | 1 | Processor address strobe, one cycle per address phase |
| p_ad | input | 64 | Processor multiplexed address/attribute bus |
| p_rdy | output | 1 | Processor-side ready pulse |
| p_rty | output | 1 | Processor-side relinquish-and-retry pulse |
| p_err | output | 1 | Processor-side bus error pulse |
| h_req | output | 1 | Host request valid |
| h_addr | output | 36 | Host request address |
| h_wr | output | 1 | Host request is a write |
| h_dw64 | output | 1 | Host data width 64 (0 = 32) |
| h_burst | output | 1 | Host burst (0 = single) |
| h_tsize | output | 2 | Single byte count: 01 = 1, 10 = 2, 00 = full |
| h_blen | output | 2 | Burst length: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bytes |
| h_more | output | 1 | Continuation: the next request is chained to this one |
| h_ack | input | 1 | Host acknowledge of the current request |
| h_err | input | 1 | Host error, valid with `h_ack` |

## Verification
Every processor-side result (ready, retry and error) is a registered pulse. It is due exactly one cycle after the clock edge that sampled its cause: the address strobe for ready on a write and for retry, and the final host acknowledge for a read's ready or error. Host attributes are due one cycle after the accepted address phase. The second chunk's address is due one cycle after the first acknowledge. The bench drives and samples on falling edges, so each check reads the value present after exactly that one rising edge. While the host side is stalled, it checks on every cycle that the request stays stable and that no response appears early.

// File: rtl/ptoh_pkg.sv
// Shared types for the processor-to-host translator.
// Assumes: the size code is 3 bits wide; the host attribute set is fixed.
package ptoh_pkg;

    // Processor transfer size code carried in the attribute field.
    typedef enum logic [2:0] {
        SZ_B1   = 3'd0,
        SZ_B2   = 3'd1,
        SZ_B4   = 3'd2,
        SZ_B8   = 3'd3,
        SZ_B16  = 3'd4,
        SZ_B32  = 3'd5,
        SZ_B64  = 3'd6,
        SZ_B128 = 3'd7
    } xfer_size_e;

    // Discrete host-side attributes derived from one processor request.
    typedef struct packed {
        logic       wr;
        logic       dw64;
        logic       burst;
        logic [1:0] tsize;
        logic [1:0] blen;
        logic       chain;   // request needs two chained host bursts
    } host_attr_t;

    // Issue sequencer states.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } issue_state_e;

endpackage

// File: rtl/xl_attr_map.sv
// Attribute mapper: turns the processor direction bit and size code into
// host width, burst, partial-size and burst-length attributes.
// Assumes: purely combinational; the caller samples the result on accept.
module xl_attr_map
    import ptoh_pkg::*;
(
    input  logic       wr_i,
    input  logic [2:0] size_i,
    output host_attr_t attr_o
);

    // Size-dependent mapping table.
    always_comb begin
        attr_o    = '0;
        attr_o.wr = wr_i;
        case (xfer_size_e'(size_i))
            SZ_B1:   attr_o.tsize = 2'b01;
            SZ_B2:   attr_o.tsize = 2'b10;
            SZ_B4:   attr_o.tsize = 2'b00;
            SZ_B8: begin
                attr_o.dw64  = 1'b1;
                attr_o.burst = 1'b1;
                attr_o.blen  = 2'd0;
            end
            SZ_B16: begin
                attr_o.dw64  = 1'b1;
                attr_o.burst = 1'b1;
                attr_o.blen  = 2'd1;
            end
            SZ_B32: begin
                attr_o.dw64  = 1'b1;
                attr_o.burst = 1'b1;
                attr_o.blen  = 2'd2;
            end
            SZ_B64: begin
                attr_o.dw64  = 1'b1;
                attr_o.burst = 1'b1;
                attr_o.blen  = 2'd3;
            end
            SZ_B128: begin
                attr_o.dw64  = 1'b1;
                attr_o.burst = 1'b1;
                attr_o.blen  = 2'd3;
                attr_o.chain = 1'b1;
            end
            default: attr_o.tsize = 2'b00;
        endcase
    end

endmodule

// File: rtl/xl_issue_fsm.sv
// Host issue sequencer: holds one captured request and presents it on the
// request/acknowledge handshake. A chained request is re-issued once at
// the next chunk address, with the continuation flag on the first part.
// Assumes: start_i is only raised while busy_o is low; h_err_i is only
// meaningful together with h_ack_i.
module xl_issue_fsm
    import ptoh_pkg::*;
#(
    parameter int ADDR_W      = 36,
    parameter int CHUNK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  host_attr_t        attr_i,
    input  logic              h_ack_i,
    input  logic              h_err_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] h_addr_o,
    output host_attr_t        h_attr_o,
    output logic              h_more_o,
    output logic              fin_o,
    output logic              fin_err_o
);

    localparam logic [ADDR_W-1:0] CHUNK_STEP = ADDR_W'(CHUNK_BYTES);

    issue_state_e state_q;
    logic         second_q;

    assign busy_o = (state_q == ST_ISSUE);

    // Transaction completes on the last acknowledge or on any error.
    assign fin_o     = busy_o && h_ack_i && (!second_q || h_err_i);
    assign fin_err_o = fin_o && h_err_i;

    // Capture the request, then advance through one or two host chunks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            second_q <= 1'b0;
            h_addr_o <= '0;
            h_attr_o <= '0;
            h_more_o <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q  <= ST_ISSUE;
                        h_addr_o <= addr_i;
                        h_attr_o <= attr_i;
                        h_more_o <= attr_i.chain;
                        second_q <= attr_i.chain;
                    end
                end
                default: begin
                    if (h_ack_i) begin
                        if (second_q && !h_err_i) begin
                            h_addr_o <= h_addr_o + CHUNK_STEP;
                            h_more_o <= 1'b0;
                            second_q <= 1'b0;
                        end else begin
                            state_q  <= ST_IDLE;
                            h_more_o <= 1'b0;
                            second_q <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    // R11: request and attributes hold while waiting for acknowledge.
    assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !h_ack_i |=> busy_o && $stable(h_addr_o) && $stable(h_attr_o)
                               && $stable(h_more_o));

    // R5: an acknowledged continuation is followed by its final chunk.
    assert_chain_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && h_more_o && h_ack_i && !h_err_i |=> busy_o && !h_more_o);

    // R9: an error acknowledge always ends the transaction.
    assert_err_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && h_ack_i && h_err_i |=> !busy_o);

endmodule

// File: rtl/xl_resp.sv
// Processor-side response generator: registers the ready, retry and
// error pulses for posted writes, refused address phases and read ends.
// Assumes: at most one of accept and retry is raised per cycle.
module xl_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_wr_i,
    input  logic retry_i,
    input  logic fin_i,
    input  logic fin_err_i,
    input  logic cur_wr_i,
    output logic p_rdy_o,
    output logic p_rty_o,
    output logic p_err_o
);

    // One-cycle response pulses, one cycle after their cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_rdy_o <= 1'b0;
            p_rty_o <= 1'b0;
            p_err_o <= 1'b0;
        end else begin
            p_rdy_o <= accept_wr_i || (fin_i && !fin_err_i && !cur_wr_i);
            p_rty_o <= retry_i;
            p_err_o <= fin_i && fin_err_i && !cur_wr_i;
        end
    end

    // R9: ready and error are never given together.
    assert_rdy_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_rdy_o && p_err_o));

    // R7: retry is never given together with ready.
    assert_rty_rdy_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_rty_o && p_rdy_o));

endmodule

// File: rtl/ptoh_xlate.sv
// Processor-to-host transaction translator top. Splits the multiplexed
// address phase into address and attribute field, maps attributes, posts
// writes, refuses new address phases while busy, and reports read ends.
// Assumes: one transaction in flight; host side completes every request.
module ptoh_xlate
    import ptoh_pkg::*;
#(
    parameter int BUS_W       = 64,
    parameter int ADDR_W      = 36,
    parameter int CHUNK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_as,
    input  logic [BUS_W-1:0]  p_ad,
    output logic              p_rdy,
    output logic              p_rty,
    output logic              p_err,
    output logic              h_req,
    output logic [ADDR_W-1:0] h_addr,
    output logic              h_wr,
    output logic              h_dw64,
    output logic              h_burst,
    output logic [1:0]        h_tsize,
    output logic [1:0]        h_blen,
    output logic              h_more,
    input  logic              h_ack,
    input  logic              h_err
);

    localparam int WR_BIT   = ADDR_W;
    localparam int SIZE_LSB = ADDR_W + 1;
    localparam int SIZE_W   = 3;
    localparam int HI_LSB   = SIZE_LSB + SIZE_W;

    host_attr_t map_attr;
    host_attr_t cur_attr;
    logic       busy;
    logic       accept;
    logic       retry;
    logic       fin;
    logic       fin_err;
    logic       unused_attr_hi;

    // Upper attribute bits carry nothing this block acts on.
    assign unused_attr_hi = ^p_ad[BUS_W-1:HI_LSB];

    // Address phase is either taken or refused.
    assign accept = p_as && !busy;
    assign retry  = p_as && busy;

    xl_attr_map u_map (
        .wr_i   (p_ad[WR_BIT]),
        .size_i (p_ad[SIZE_LSB +: SIZE_W]),
        .attr_o (map_attr)
    );

    xl_issue_fsm #(
        .ADDR_W      (ADDR_W),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept),
        .addr_i    (p_ad[ADDR_W-1:0]),
        .attr_i    (map_attr),
        .h_ack_i   (h_ack),
        .h_err_i   (h_err),
        .busy_o    (busy),
        .h_addr_o  (h_addr),
        .h_attr_o  (cur_attr),
        .h_more_o  (h_more),
        .fin_o     (fin),
        .fin_err_o (fin_err)
    );

    xl_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_wr_i (accept && p_ad[WR_BIT]),
        .retry_i     (retry),
        .fin_i       (fin),
        .fin_err_i   (fin_err),
        .cur_wr_i    (cur_attr.wr),
        .p_rdy_o     (p_rdy),
        .p_rty_o     (p_rty),
        .p_err_o     (p_err)
    );

    // Drive the discrete host attribute pins.
    assign h_req   = busy;
    assign h_wr    = cur_attr.wr;
    assign h_dw64  = cur_attr.dw64;
    assign h_burst = cur_attr.burst;
    assign h_tsize = cur_attr.tsize;
    assign h_blen  = cur_attr.blen;

    // R4: every host burst is 64 bits wide with a full size code.
    assert_burst_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && h_burst |-> h_dw64 && (h_tsize == 2'b00));

    // R2: singles are always 32 bits wide with no burst length.
    assert_single_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && !h_burst |-> !h_dw64 && (h_blen == 2'd0) && !h_more);

    // R7: a retry pulse only follows an address strobe.
    assert_rty_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        p_rty |-> $past(p_as));

    // R6: an accepted write is answered ready in the next cycle.
    assert_wr_posted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        p_as && !h_req && p_ad[WR_BIT] |=> p_rdy && h_req);

endmodule

// File: tb/ptoh_xlate_tb.sv
`timescale 1ns/1ps
module ptoh_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p_as = 1'b0;
    logic [63:0] p_ad = '0;
    logic        p_rdy, p_rty, p_err;
    logic        h_req, h_wr, h_dw64, h_burst, h_more;
    logic [35:0] h_addr;
    logic [1:0]  h_tsize, h_blen;
    logic        h_ack = 1'b0;
    logic        h_err = 1'b0;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ptoh_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .p_as(p_as), .p_ad(p_ad),
        .p_rdy(p_rdy), .p_rty(p_rty), .p_err(p_err),
        .h_req(h_req), .h_addr(h_addr), .h_wr(h_wr), .h_dw64(h_dw64),
        .h_burst(h_burst), .h_tsize(h_tsize), .h_blen(h_blen),
        .h_more(h_more), .h_ack(h_ack), .h_err(h_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Expected host attributes {dw64, burst, tsize, blen, chain} from R2-R5.
    function automatic logic [6:0] exp_attr(input logic [2:0] sz);
        case (sz)
            3'd0: return {1'b0, 1'b0, 2'b01, 2'd0, 1'b0};
            3'd1: return {1'b0, 1'b0, 2'b10, 2'd0, 1'b0};
            3'd2: return {1'b0, 1'b0, 2'b00, 2'd0, 1'b0};
            3'd3: return {1'b1, 1'b1, 2'b00, 2'd0, 1'b0};
            3'd4: return {1'b1, 1'b1, 2'b00, 2'd1, 1'b0};
            3'd5: return {1'b1, 1'b1, 2'b00, 2'd2, 1'b0};
            3'd6: return {1'b1, 1'b1, 2'b00, 2'd3, 1'b0};
            default: return {1'b1, 1'b1, 2'b00, 2'd3, 1'b1};
        endcase
    endfunction

    // One processor transaction with host stall, optional retry poke and error.
    task automatic run_txn(input bit wr, input logic [2:0] sz, input logic [35:0] a,
                           input int stall, input bit poke, input bit err);
        logic [6:0]  ea;
        logic [35:0] cur;
        bit          done;
        ea  = exp_attr(sz);
        cur = a;
        done = 1'b0;
        @(negedge clk);
        p_as = 1'b1;
        p_ad = {24'($urandom), sz, wr, a};
        @(negedge clk);
        p_as = 1'b0;
        chk("R1 h_req", h_req, 1);
        chk("R1 h_addr", h_addr, a);
        chk("R1 h_wr", h_wr, wr);
        chk("R2/R3/R4 attrs", {h_dw64, h_burst, h_tsize, h_blen}, ea[6:1]);
        chk("R5 h_more first", h_more, ea[0]);
        chk("R6 posted ready", p_rdy, wr);
        for (int c = 0; c < 2 && !done; c++) begin
            for (int i = 0; i < stall; i++) begin
                if (poke && i == 0) begin
                    p_as = 1'b1;
                    p_ad = {24'($urandom), 3'($urandom), 1'b1, 36'($urandom)};
                    @(negedge clk);
                    p_as = 1'b0;
                    chk("R7 retry", p_rty, 1);
                    chk("R7 no ready", p_rdy, 0);
                    chk("R7 no error", p_err, 0);
                    chk("R7 addr kept", h_addr, cur);
                    chk("R7 attrs kept", {h_wr, h_dw64, h_burst, h_tsize, h_blen}, {wr, ea[6:1]});
                end else begin
                    @(negedge clk);
                    chk("R11 req held", {h_req, h_addr}, {1'b1, cur});
                    chk("R8 no early ready", p_rdy, 0);
                end
            end
            h_ack = 1'b1;
            h_err = err;
            @(negedge clk);
            h_ack = 1'b0;
            h_err = 1'b0;
            if (c == 0 && ea[0] && !err) begin
                cur = a + 36'd64;
                chk("R5 second req", h_req, 1);
                chk("R5 second addr", h_addr, cur);
                chk("R5 second more", h_more, 0);
                chk("R5 second blen", h_blen, 2'd3);
                chk("R8 mid ready", p_rdy, 0);
            end else begin
                done = 1'b1;
                chk("R9 req ends", h_req, 0);
                if (wr) begin
                    chk("R6 no ready on host end", p_rdy, 0);
                    chk("R6 no error on write", p_err, 0);
                end else begin
                    chk("R8 read ready", p_rdy, !err);
                    chk("R9 read error", p_err, err);
                end
            end
        end
        @(negedge clk);
        chk("R8 single pulse", {p_rdy, p_err, p_rty}, 3'b000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R11 watchdog act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {h_req, h_more, p_rdy, p_rty, p_err}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after release", {h_req, h_more, p_rdy, p_rty, p_err}, 5'b0);
        // R11: stray acknowledge while idle has no effect.
        h_ack = 1'b1;
        h_err = 1'b1;
        @(negedge clk);
        h_ack = 1'b0;
        h_err = 1'b0;
        chk("R11 stray ack", {h_req, p_rdy, p_err}, 3'b000);
        // Directed: every size, read and write.
        for (int s = 0; s < 8; s++) begin
            run_txn(1'b0, 3'(s), 36'h0_1234_5670 + 36'(s), 1, 1'b0, 1'b0);
            run_txn(1'b1, 3'(s), 36'h8_0000_0000 + 36'(s * 8), 2, 1'b0, 1'b0);
        end
        // R5: chain wraps at the top of the address space.
        run_txn(1'b0, 3'd7, 36'hF_FFFF_FFE0, 0, 1'b0, 1'b0);
        // R7: retry during posted write and during a read.
        run_txn(1'b1, 3'd2, 36'h0_0000_0100, 3, 1'b1, 1'b0);
        run_txn(1'b0, 3'd6, 36'h0_0000_0200, 2, 1'b1, 1'b0);
        // R9: error on first chunk of a chain, on a read and on a write.
        run_txn(1'b0, 3'd7, 36'h1_0000_0000, 1, 1'b0, 1'b1);
        run_txn(1'b0, 3'd0, 36'h2_0000_0003, 0, 1'b0, 1'b1);
        run_txn(1'b1, 3'd7, 36'h3_0000_0000, 1, 1'b1, 1'b1);
        // Constrained random mix.
        for (int n = 0; n < 300; n++) begin
            run_txn(1'($urandom), 3'($urandom), 36'($urandom) ^ {4'($urandom), 32'd0},
                    int'($urandom_range(0, 4)), ($urandom_range(0, 3) == 0),
                    ($urandom_range(0, 7) == 0));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule